// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block takes an SDRAM device into and out of its self-refresh state. It drives the clock-enable pin and a two-bit command code (no-operation or refresh) toward the memory. A controller asks for sleep with `sleep_req`, asks for wake-up with `wake_req`, and reports through `clk_stable` that the memory clock is running within its limits again.

To enter, the block issues one refresh command with clock-enable low in the same cycle. It then holds clock-enable low for at least the minimum residency. A wake request that arrives too early is remembered and acted on once that residency has passed. To leave, it waits for a stable clock before raising clock-enable. It then sends no-operation commands for the exit recovery time, with a floor of two cycles. Next comes the mandatory auto-refresh, and after the refresh cycle time has passed, `ready` rises again.

All timing values are parameters counted in clock cycles: `T_RAS_CYC`, `T_XSR_CYC` and `T_RC_CYC`. All outputs come straight from registers.

Top module: `sref_sequencer`

## Requirements
- R1: After reset, `cke` is 1, `cmd` is 2'b00 (NOP), `in_sr` is 0 and `ready` is 1.
- R2: When `sleep_req` is sampled high while idle at edge E, the outputs after E show `cmd` = 2'b01 (REFRESH) with `cke` = 0 for exactly one cycle, and `in_sr` rises at the same edge.
- R3: For the whole time `in_sr` is 1, `cke` is 0 and `ready` is 0. The only command after the entry refresh is NOP until `cke` rises.
- R4: `cke` stays low for at least `T_RAS_CYC`+2 cycles from the entry refresh. A wake request seen during entry or residency is kept, and with a stable clock `cke` rises at edge E+`T_RAS_CYC`+2.
- R5: `cke` rises only at the edge after the one where `clk_stable` was sampled high in the wait state. If the clock is already stable, that is the edge after the wake was accepted.
- R6: After `cke` rises, `cmd` is NOP for exactly max(`T_XSR_CYC`,2) cycles. Then one REFRESH (2'b01) is issued with `cke` = 1.
- R7: `ready` stays 0 after the exit refresh and rises `T_RC_CYC`+1 cycles after the edge that shows that refresh.
- R8: `wake_req` has no effect while idle, and `sleep_req` has no effect while not idle. Neither produces a command or a change of `cke`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Memory clock is stable |
| cke | output | 1 | Clock-enable toward the SDRAM |
| cmd | output | 2 | Command code: 2'b00 NOP, 2'b01 REFRESH |
| in_sr | output | 1 | Device is held in self-refresh |
| ready | output | 1 | Device is usable for normal traffic |

## Verification
A wrong state or a mis-loaded timer shows up at the pins as a clock-enable edge or a refresh command in the wrong cycle. It can also show as `ready` rising too early. Each of these appears within one sequence, at most a few tens of cycles after the request. The bench therefore predicts the exact edge of each of the four visible events of a sleep/wake round trip: entry refresh, clock-enable rise, exit refresh and `ready` rise. It does this for an early wake, a late wake behind a slow clock, and a wake that coincides with the sleep request. Any event that is extra, missing or shifted by even one cycle is reported.

// File: rtl/sref_pkg.sv
package sref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_IN_SR,
    ST_WAIT_CLK,
    ST_EXIT_NOP,
    ST_POST_REF,
    ST_RECOVER
  } sref_state_e;

  localparam logic [1:0] CMD_NOP = 2'b00;
  localparam logic [1:0] CMD_REF = 2'b01;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sref_fsm.sv
module sref_fsm
  import sref_pkg::*;
#(
  parameter int T_RAS_CYC = 6,
  parameter int NOP_LEN   = 2,
  parameter int T_RC_CYC  = 4,
  parameter int CW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  input  logic          wake_req,
  input  logic          clk_stable,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cke,
  output logic [1:0]    cmd,
  output logic          in_sr,
  output logic          ready
);

  sref_state_e state, nxt;
  logic        wake_pend;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (sleep_req) nxt = ST_ENTER;
      ST_ENTER:    nxt = ST_IN_SR;
      ST_IN_SR:    if (tmr_done && (wake_pend || wake_req)) nxt = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clk_stable) nxt = ST_EXIT_NOP;
      ST_EXIT_NOP: if (tmr_done) nxt = ST_POST_REF;
      ST_POST_REF: nxt = ST_RECOVER;
      ST_RECOVER:  if (tmr_done) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (nxt != state) begin
      unique case (nxt)
        ST_IN_SR:    begin tmr_load = 1'b1; tmr_val = CW'(T_RAS_CYC - 1); end
        ST_EXIT_NOP: begin tmr_load = 1'b1; tmr_val = CW'(NOP_LEN - 1);   end
        ST_RECOVER:  begin tmr_load = 1'b1; tmr_val = CW'(T_RC_CYC - 1);  end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wake_pend <= 1'b0;
      cke       <= 1'b1;
      cmd       <= CMD_NOP;
      in_sr     <= 1'b0;
      ready     <= 1'b1;
    end else begin
      state <= nxt;
      if (state == ST_IN_SR && nxt != ST_IN_SR)
        wake_pend <= 1'b0;
      else if ((state == ST_ENTER || state == ST_IN_SR) && wake_req)
        wake_pend <= 1'b1;
      cke   <= !(nxt inside {ST_ENTER, ST_IN_SR, ST_WAIT_CLK});
      in_sr <= (nxt inside {ST_ENTER, ST_IN_SR, ST_WAIT_CLK});
      cmd   <= (nxt == ST_ENTER || nxt == ST_POST_REF) ? CMD_REF : CMD_NOP;
      ready <= (nxt == ST_IDLE);
    end
  end

  // Checker counters: cycles with cke low, NOP cycles since cke rose
  localparam int LW = $clog2(T_RAS_CYC + 3) + 1;
  localparam int NW = $clog2(NOP_LEN + 1) + 1;
  logic [LW-1:0] low_cnt;
  logic [NW-1:0] nop_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      nop_cnt <= '0;
    end else begin
      if (cke)
        low_cnt <= '0;
      else if (low_cnt != {LW{1'b1}})
        low_cnt <= low_cnt + 1'b1;
      if (!cke)
        nop_cnt <= '0;
      else if (cmd == CMD_NOP && nop_cnt != {NW{1'b1}})
        nop_cnt <= nop_cnt + 1'b1;
    end
  end

  p_entry_ref_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && !cke) |-> $rose(in_sr));

  p_low_in_sr_r3: assert property (@(posedge clk) disable iff (rst)
    in_sr |-> (!cke && !ready));

  p_residency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (int'(low_cnt) >= T_RAS_CYC + 2));

  p_rise_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> ($past(clk_stable) && cmd == CMD_NOP));

  p_nop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && cke) |-> (int'(nop_cnt) >= NOP_LEN));

  p_no_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF && cke) |=> !ready);

endmodule

// File: rtl/sref_sequencer.sv
module sref_sequencer
  import sref_pkg::*;
#(
  parameter int T_RAS_CYC = 6,
  parameter int T_XSR_CYC = 1,
  parameter int T_RC_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       clk_stable,
  output logic       cke,
  output logic [1:0] cmd,
  output logic       in_sr,
  output logic       ready
);

  localparam int NOP_LEN = imax(T_XSR_CYC, 2);
  localparam int MAX_T   = imax(imax(T_RAS_CYC, NOP_LEN), T_RC_CYC);
  localparam int CW      = $clog2(MAX_T) + 1;

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;

  sref_timer #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sref_fsm #(
    .T_RAS_CYC (T_RAS_CYC),
    .NOP_LEN   (NOP_LEN),
    .T_RC_CYC  (T_RC_CYC),
    .CW        (CW)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .clk_stable (clk_stable),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cke        (cke),
    .cmd        (cmd),
    .in_sr      (in_sr),
    .ready      (ready)
  );

endmodule

// File: tb/sref_sequencer_tb_top.sv
`timescale 1ns/1ps
module sref_sequencer_tb_top;

  localparam int T_RAS   = 6;
  localparam int T_XSR   = 1;
  localparam int T_RC    = 4;
  localparam int NOP_EXP = (T_XSR > 2) ? T_XSR : 2;

  localparam int EV_ENTRY = 0, EV_RISE = 1, EV_EXITREF = 2, EV_READY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b1;
  logic cke, in_sr, ready;
  logic [1:0] cmd;

  int cyc = 0;
  int checks = 0, fails = 0;
  int exp_kind[$];
  int exp_cyc[$];
  logic mon_en = 1'b0;
  logic prev_cke, prev_ready;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sref_sequencer #(.T_RAS_CYC(T_RAS), .T_XSR_CYC(T_XSR), .T_RC_CYC(T_RC)) dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .cke(cke), .cmd(cmd), .in_sr(in_sr), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Driver side: push one full round trip of expected events
  task automatic push_exit(input int rise);
    exp_kind.push_back(EV_RISE);    exp_cyc.push_back(rise);
    exp_kind.push_back(EV_EXITREF); exp_cyc.push_back(rise + NOP_EXP);
    exp_kind.push_back(EV_READY);   exp_cyc.push_back(rise + NOP_EXP + 1 + T_RC);
  endtask

  // Monitor: compare each visible event against the head of the queue
  task automatic see_event(input int kind, input string req);
    if (exp_kind.size() == 0) begin
      chk(1'b0, req, kind, -1);
    end else begin
      int k, c;
      k = exp_kind.pop_front();
      c = exp_cyc.pop_front();
      chk(k == kind, req, kind, k);
      chk(c == cyc, req, cyc, c);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (cmd == 2'b01 && !cke) see_event(EV_ENTRY, "R2 entry refresh");
      if (cke && !prev_cke)     see_event(EV_RISE, "R4/R5 cke rise");
      if (cmd == 2'b01 && cke)  see_event(EV_EXITREF, "R6 exit refresh");
      if (ready && !prev_ready) see_event(EV_READY, "R7 ready rise");
      if (!cke && cmd != 2'b00 && !(cmd == 2'b01 && in_sr && !prev_cke == 1'b0))
        chk(1'b0, "R3 only NOP while low", int'(cmd), 0);
    end
    prev_cke   <= cke;
    prev_ready <= ready;
  end

  task automatic wait_ready();
    int n = 0;
    @(negedge clk);
    while (!ready && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin : main
    int e, c2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cke == 1'b1, "R1 cke", int'(cke), 1);
    chk(cmd == 2'b00, "R1 cmd", int'(cmd), 0);
    chk(in_sr == 1'b0, "R1 in_sr", int'(in_sr), 0);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    mon_en = 1'b1;

    // R8: wake while idle has no effect
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(cke && !in_sr && ready, "R8 wake ignored in idle", int'(cke), 1);

    // Scenario A: wake during entry, clock stable (R2..R7)
    e = cyc + 1;
    exp_kind.push_back(EV_ENTRY); exp_cyc.push_back(e);
    push_exit(e + T_RAS + 2);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    wake_req  = 1'b1;
    @(negedge clk);
    wake_req  = 1'b0;
    sleep_req = 1'b1;                 // R8: sleep while asleep ignored
    chk(in_sr && !cke && !ready, "R3 held in self-refresh", int'(in_sr), 1);
    @(negedge clk);
    sleep_req = 1'b0;
    wait_ready();
    repeat (3) @(negedge clk);

    // Scenario B: late wake, slow clock (R4, R5)
    clk_stable = 1'b0;
    e = cyc + 1;
    exp_kind.push_back(EV_ENTRY); exp_cyc.push_back(e);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    repeat (T_RAS + 4) @(negedge clk);
    chk(in_sr && !cke, "R4 stays asleep without wake", int'(cke), 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!cke, "R5 cke low until clock stable", int'(cke), 0);
    end
    c2 = cyc;
    push_exit(c2 + 1);
    clk_stable = 1'b1;
    wait_ready();
    repeat (3) @(negedge clk);

    // Scenario C: wake with sleep (ignored), then wake mid-residency
    e = cyc + 1;
    exp_kind.push_back(EV_ENTRY); exp_cyc.push_back(e);
    push_exit(e + T_RAS + 2);
    sleep_req = 1'b1;
    wake_req  = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    wake_req  = 1'b0;
    repeat (3) @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    wait_ready();
    repeat (4) @(negedge clk);
    chk(cke && ready && cmd == 2'b00, "R7 back to normal", int'(ready), 1);
    chk(exp_kind.size() == 0, "R2-all events seen", exp_kind.size(), 0);

    report();
    $finish;
  end

endmodule